// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers every interrupt request of a peripheral subsystem into one pending-status word and drives a single request line toward the host. Four lines come from GPIO banks, which do their own masking and latching, and are shown in the status word exactly as they are. Six lines come from other peripherals. The aggregator catches a rising edge on each of these and holds it until software acknowledges it.

Software sees two 16-bit registers behind a small read/write strobe interface. The status register is at address 0 and the mask register at address 1. The mask register holds one enable bit per peripheral source and one global enable. The host line goes high when the global enable is set and any enabled status bit is set.

The host treats the line as edge sensitive. For this reason every status read pulls the line low for one cycle. If work is still pending after service, the line rises again and the host sees a fresh edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask register reads 0x0000, the status register reads 0x0000 while all inputs are low, and `host_irq` is low.
- R2: A read strobe with `reg_addr` returns the addressed register on `reg_rdata` one clock later. Status bits 3:0 are the live levels of bank lines A, B, C and D, in that order. Bits 9:4 are the pending flags of peripheral sources 0 to 5. Bits 15:10 read as zero.
- R3: A peripheral pending flag is set by a rising edge of its source. The flag stays set after the source falls. A source that is held high does not set the flag again once it has been cleared.
- R4: Writing 1 to status bit 4+i clears pending flag i, and writing 0 leaves it unchanged. A status write does not change the bank bits. A rising edge in the same cycle as a clearing write leaves the flag set.
- R5: In the mask register, bit i (0 to 5) enables peripheral source i, and bit 15 is the global enable. All other mask bits read as zero whatever is written to them.
- R6: One clock after the condition holds, `host_irq` equals the global enable AND (any bank line high OR any pending flag whose enable bit is set). With the global enable clear, the line is low.
- R7: In the cycle that follows a status read strobe, `host_irq` is low. After that it takes the value R6 gives again. A mask read does not pull it low.
- R8: Reads of addresses 2 and 3 return zero. Writes to addresses 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_irq | input | 4 | Interrupt lines of GPIO banks A..D |
| periph_src | input | 6 | Peripheral interrupt sources, edge captured |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the strobe |
| host_irq | output | 1 | Interrupt request toward the host |

## Verification
A table of input patterns is applied in turn. Each pattern sets the bank lines, a burst of peripheral edges and a mask value. The patterns separate four cases: global enable off, a source pending but not enabled, an enable bit set on the wrong source, and a bank line asserting alone. Each pattern shows whether the output follows the enabled set rather than the raw set. Directed sequences then check that a flag outlives its source, that a held level is not captured again, that clearing is partial and leaves the bank bits alone, and that an edge arriving with a clear wins. They also check that the output drops after a status read but not after a mask read, and that the unused addresses have no effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned IA_NUM_BANKS  = 4;
    localparam int unsigned IA_NUM_PERIPH = 6;
    localparam int unsigned IA_DATA_W     = 16;
    localparam int unsigned IA_ADDR_W     = 2;
    localparam int unsigned IA_GLOBAL_BIT = 15;

    typedef enum logic [IA_ADDR_W-1:0] {
        IA_REG_STATUS = 2'd0,
        IA_REG_MASK   = 2'd1
    } ia_reg_e;
endpackage

// File: rtl/irq_agg_edge_latch.sv
module irq_agg_edge_latch #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.prev = src;
        for (int i = 0; i < N; i++) begin
            // a new edge takes priority over an acknowledge in the same cycle
            if (src[i] && !st_q.prev[i]) begin
                st_d.pend[i] = 1'b1;
            end else if (clr[i]) begin
                st_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_agg_mask_reg.sv
module irq_agg_mask_reg #(
    parameter int unsigned N    = 6,
    parameter int unsigned DW   = 16,
    parameter int unsigned GBIT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  periph_en,
    output logic          glob_en,
    output logic [DW-1:0] rd_val
);
    typedef struct packed {
        logic [N-1:0] en;
        logic         glob;
    } mask_t;

    mask_t st_d, st_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en   = wdata[N-1:0];
            st_d.glob = wdata[GBIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < DW; b++) begin : g_rd
        if (b < N) begin : g_en
            assign rd_val[b] = st_q.en[b];
        end else if (b == GBIT) begin : g_glob
            assign rd_val[b] = st_q.glob;
        end else begin : g_zero
            assign rd_val[b] = 1'b0;
        end
    end

    assign periph_en = st_q.en;
    assign glob_en   = st_q.glob;
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
    parameter int unsigned NB = 4,
    parameter int unsigned NP = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank,
    input  logic [NP-1:0] pend,
    input  logic [NP-1:0] periph_en,
    input  logic          glob_en,
    input  logic          status_rd,
    output logic          irq
);
    typedef struct packed {
        logic irq;
    } out_t;

    out_t st_d, st_q;
    logic any_work;

    always_comb begin
        any_work = (|bank) || (|(pend & periph_en));
        st_d = st_q;
        // a status read forces a low cycle so remaining work re-edges the line
        st_d.irq = glob_en && any_work && !status_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = IA_NUM_BANKS,
    parameter int unsigned NUM_PERIPH = IA_NUM_PERIPH,
    parameter int unsigned DATA_W     = IA_DATA_W,
    parameter int unsigned ADDR_W     = IA_ADDR_W,
    parameter int unsigned GLOBAL_BIT = IA_GLOBAL_BIT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_irq,
    input  logic [NUM_PERIPH-1:0] periph_src,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  host_irq
);
    localparam int unsigned STAT_W = NUM_BANKS + NUM_PERIPH;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t st_d, st_q;

    logic                  sel_status, sel_mask;
    logic                  status_rd_w, mask_wr_w;
    logic [NUM_PERIPH-1:0] clr_w, pend_w, en_w;
    logic                  glob_en_w;
    logic [DATA_W-1:0]     mask_val_w, status_word;

    always_comb begin
        sel_status  = (reg_addr == ADDR_W'(IA_REG_STATUS));
        sel_mask    = (reg_addr == ADDR_W'(IA_REG_MASK));
        status_rd_w = reg_rd && sel_status;
        mask_wr_w   = reg_wr && sel_mask;
        clr_w       = (reg_wr && sel_status) ? reg_wdata[STAT_W-1:NUM_BANKS] : '0;
        status_word = '0;
        status_word[STAT_W-1:0] = {pend_w, bank_irq};
    end

    always_comb begin
        st_d = st_q;
        if (reg_rd) begin
            if (sel_status) begin
                st_d.rdata = status_word;
            end else if (sel_mask) begin
                st_d.rdata = mask_val_w;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;

    irq_agg_edge_latch #(.N(NUM_PERIPH)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (periph_src),
        .clr  (clr_w),
        .pend (pend_w)
    );

    irq_agg_mask_reg #(.N(NUM_PERIPH), .DW(DATA_W), .GBIT(GLOBAL_BIT)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mask_wr_w),
        .wdata    (reg_wdata),
        .periph_en(en_w),
        .glob_en  (glob_en_w),
        .rd_val   (mask_val_w)
    );

    irq_agg_out #(.NB(NUM_BANKS), .NP(NUM_PERIPH)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank     (bank_irq),
        .pend     (pend_w),
        .periph_en(en_w),
        .glob_en  (glob_en_w),
        .status_rd(status_rd_w),
        .irq      (host_irq)
    );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int unsigned NB = 4,
    parameter int unsigned NP = 6,
    parameter int unsigned AW = 2,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [NB-1:0] bank_irq,
    input logic [NP-1:0] periph_src,
    input logic          host_irq,
    input logic [NP-1:0] pend,
    input logic          glob_en
);
    logic stat_sel;
    assign stat_sel = (reg_addr == '0);

    // R7: the cycle after a status read the request line is low
    assert_drop_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && stat_sel) |=> !host_irq);

    // R6: global enable clear keeps the line low
    assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !host_irq);

    // R6: a bank line with global enable raises the line
    assert_bank_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && (|bank_irq) && !(reg_rd && stat_sel)) |=> host_irq);

    for (genvar i = 0; i < NP; i++) begin : g_src
        // R3: a flag only rises when its source was high
        assert_pend_from_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(periph_src[i]));

        // R4: acknowledge without a competing edge clears the flag
        assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && stat_sel && reg_wdata[NB+i] && !periph_src[i]) |=> !pend[i]);
    end
endmodule

bind irq_aggregator irq_agg_checker #(
    .NB(NUM_BANKS), .NP(NUM_PERIPH), .AW(ADDR_W), .DW(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .bank_irq  (bank_irq),
    .periph_src(periph_src),
    .host_irq  (host_irq),
    .pend      (pend_w),
    .glob_en   (glob_en_w)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank_irq = '0;
    logic [5:0]  periph_src = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        host_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .bank_irq(bank_irq), .periph_src(periph_src),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    typedef struct packed {
        logic [3:0]  bank;
        logic [5:0]  src;
        logic [15:0] mask;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 6'h00, 16'h8000, 1'b0},
        '{4'h1, 6'h00, 16'h0000, 1'b0},
        '{4'h1, 6'h00, 16'h8000, 1'b1},
        '{4'h0, 6'h01, 16'h8000, 1'b0},
        '{4'h0, 6'h01, 16'h8001, 1'b1},
        '{4'h0, 6'h20, 16'h0020, 1'b0},
        '{4'h0, 6'h20, 16'h801F, 1'b0},
        '{4'h8, 6'h15, 16'h802A, 1'b1},
        '{4'h0, 6'h15, 16'h802A, 1'b0},
        '{4'h0, 6'h3F, 16'h803F, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 host_irq", {15'b0, host_irq}, 16'h0000);
        rd(2'd1, v); check("R1 mask", v, 16'h0000);
        rd(2'd0, v); check("R1 status", v, 16'h0000);

        // R5 unimplemented mask bits
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v); check("R5 mask readback", v, 16'h803F);

        // table walk: R2 R3 R5 R6
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            bank_irq = '0; periph_src = '0;
            wr(2'd0, 16'h03F0);
            wr(2'd1, VEC[k].mask);
            bank_irq = VEC[k].bank; periph_src = VEC[k].src;
            repeat (3) @(negedge clk);
            check($sformatf("R6 vec%0d host_irq", k), {15'b0, host_irq}, {15'b0, VEC[k].exp_irq});
            rd(2'd1, v);
            check($sformatf("R5 vec%0d mask", k), v, VEC[k].mask & 16'h803F);
            rd(2'd0, v);
            check($sformatf("R2 vec%0d status", k), v, {6'b0, VEC[k].src, VEC[k].bank});
        end

        // R3 flag outlives source, held level not re-captured
        @(negedge clk);
        bank_irq = '0; periph_src = '0;
        wr(2'd0, 16'h03F0);
        wr(2'd1, 16'h8001);
        periph_src = 6'h01;
        @(negedge clk); periph_src = 6'h00;
        repeat (2) @(negedge clk);
        rd(2'd0, v); check("R3 latched after fall", v, 16'h0010);
        periph_src = 6'h01;
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h0010);
        repeat (2) @(negedge clk);
        check("R3 held level host_irq", {15'b0, host_irq}, 16'h0000);
        rd(2'd0, v); check("R3 held level no recapture", v, 16'h0000);

        // R4 partial clear and bank bits untouched
        periph_src = 6'h00;
        @(negedge clk); periph_src = 6'h03;
        @(negedge clk); periph_src = 6'h00;
        rd(2'd0, v); check("R4 two pending", v, 16'h0030);
        wr(2'd0, 16'h0010);
        rd(2'd0, v); check("R4 partial clear", v, 16'h0020);
        bank_irq = 4'h5;
        wr(2'd0, 16'h000F);
        rd(2'd0, v); check("R4 bank bits unaffected", v, 16'h0025);
        bank_irq = 4'h0;
        wr(2'd0, 16'h03F0);

        // R4 edge in same cycle as clear wins
        @(negedge clk);
        periph_src = 6'h04; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0040;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, v); check("R4 set wins over clear", v, 16'h0040);

        // R7 drop after status read, not after mask read
        wr(2'd1, 16'h8004);
        repeat (2) @(negedge clk);
        check("R7 pending raises", {15'b0, host_irq}, 16'h0001);
        rd(2'd0, v);
        check("R7 low after status read", {15'b0, host_irq}, 16'h0000);
        @(negedge clk);
        check("R7 re-edge", {15'b0, host_irq}, 16'h0001);
        rd(2'd1, v);
        check("R7 mask read keeps line", {15'b0, host_irq}, 16'h0001);

        // R8 unused addresses
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'h0000);
        rd(2'd1, v); check("R8 mask unchanged", v, 16'h8004);
        rd(2'd0, v); check("R8 status unchanged", v, 16'h0040);
        rd(2'd3, v); check("R8 read zero", v, 16'h0000);

        finish_run();
    end
endmodule